// File: doc/BRIEF.md
# Two-Phase Serial Frame Transmitter

This block turns parallel data words into a synchronous serial bit stream. It moves forward one bit on each cycle where the bit-clock enable is high. A frame-sync input starts each frame. A frame has two phases. Each phase has its own element length code and its own element count. A single-phase option ends the frame after the first phase.

Words come in through a valid/ready handshake. The block takes one word at the bit tick on which each element is loaded. If no word is offered at that tick, the previous word is sent again and an underrun flag is raised. The default bit order is MSB first. A second mode sends 8-bit elements LSB first. Two more modes are for companded traffic. In those modes the block does no conversion: it sends a code that was already companded, as 8 bits MSB first. A bad configuration is refused at frame start and reported.

A flag decides what happens when a frame sync arrives in the middle of a frame. With the flag clear, the transfer restarts. With the flag set, the sync is ignored.

Top module: `ser2ph_tx`

## Requirements
- R1: Element length codes map to bit counts: 0→8, 1→12, 2→16, 3→20, 4→24, 5→32. Only the low `length` bits of a word are sent.
- R2: A frame start is refused in two cases, and then `cfg_err` goes to 1, `frame_active` stays 0 and no word is taken. Case one: a reserved length code (6 or 7) in phase 1, or in phase 2 when two phases are selected. Case two: a non-zero `fmt_mode` with a length code other than 0 in a phase in use. The next accepted start clears `cfg_err`.
- R3: `fmt_mode` 0, 2 and 3 send each element MSB first. `fmt_mode` 1 sends it LSB first.
- R4: Phase 1 sends `cnt1`+1 elements of the phase-1 length. Then phase 2 sends `cnt2`+1 elements of the phase-2 length. With `one_phase`=1 the frame ends after phase 1.
- R5: Rules for frame start and timing:
  - A high `fsync` on a bit tick while idle starts a frame, and bit 0 appears on `sdo` after that tick.
  - Each element lasts `length` ticks, and the next element follows with no gap.
  - `frame_active` falls on the tick after the last bit.
- R6: With `fs_ignore`=0, `fsync` on a tick in mid-frame restarts the frame. It takes a new word and sends again from phase 1, element 1, bit 0.
- R7: With `fs_ignore`=1, `fsync` in mid-frame has no effect on the bit stream.
- R8: `fsync` on the tick that ends a frame starts the next frame at once, whatever the value of `fs_ignore`.
- R9: `word_ready` is high only on ticks that load an element. If `word_valid` is low then, `underrun` is set and the previous word is sent again. The next load with a valid word clears `underrun`.
- R10: `sdo` and `frame_active` change only on bit ticks, and `sdo` is 0 while idle.
- R11: After reset, `sdo`, `frame_active`, `cfg_err`, `underrun` and `word_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_en | input | 1 | Bit tick enable |
| fsync | input | 1 | Frame sync, sampled on bit ticks |
| len1_code | input | 3 | Phase-1 element length code |
| len2_code | input | 3 | Phase-2 element length code |
| cnt1 | input | CNT_W | Phase-1 elements minus one |
| cnt2 | input | CNT_W | Phase-2 elements minus one |
| one_phase | input | 1 | Frame has phase 1 only |
| fmt_mode | input | 2 | Bit order / companded-code mode |
| fs_ignore | input | 1 | Ignore mid-frame frame sync |
| word_in | input | 32 | Data word |
| word_valid | input | 1 | Data word offered |
| word_ready | output | 1 | Word taken on this tick |
| sdo | output | 1 | Serial data out |
| frame_active | output | 1 | Frame in progress |
| cfg_err | output | 1 | Last start refused for bad config |
| underrun | output | 1 | Last element load had no word |

## Verification
The bound checker checks the following on every cycle:
- Output stability between bit ticks, and a quiet `sdo` while idle.
- `word_ready` occurs only on ticks, and the underrun flag follows each unserved load.
- A frame never rises without a sampled sync, and never runs alongside a configuration error.

Only the bench scenarios can show the rest:
- the exact bit order and element lengths across the two phases;
- the restart-or-ignore choice for mid-frame syncs;
- back-to-back frames;
- which word gets resent on an underrun.

// File: rtl/ser2ph_tx.sv
module ser2ph_tx #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_en,
  input  logic             fsync,
  input  logic [2:0]       len1_code,
  input  logic [2:0]       len2_code,
  input  logic [CNT_W-1:0] cnt1,
  input  logic [CNT_W-1:0] cnt2,
  input  logic             one_phase,
  input  logic [1:0]       fmt_mode,
  input  logic             fs_ignore,
  input  logic [31:0]      word_in,
  input  logic             word_valid,
  output logic             word_ready,
  output logic             sdo,
  output logic             frame_active,
  output logic             cfg_err,
  output logic             underrun
);
  localparam int WW = 32;
  localparam int BW = $clog2(WW);

  function automatic logic [BW:0] code_bits(input logic [2:0] c);
    return (c == 3'd5) ? (BW+1)'(WW) : (BW+1)'(8) + {1'b0, c, 2'b00};
  endfunction

  logic [WW-1:0]    shreg, last_word;
  logic [BW-1:0]    bitcnt;
  logic [CNT_W-1:0] elem_left;
  logic             phase, lsb_q, active;

  wire bad_len  = (len1_code[2:1] == 2'b11) || (!one_phase && len2_code[2:1] == 2'b11);
  wire bad_mode = (fmt_mode != 2'b00) && (len1_code != 3'd0 || (!one_phase && len2_code != 3'd0));
  wire cfg_bad  = bad_len || bad_mode;

  wire elem_end   = active && (bitcnt == '0);
  wire frame_last = (elem_left == '0) && (phase || one_phase);
  wire start_req  = fsync && (!active || !fs_ignore || (elem_end && frame_last));
  wire next_load  = elem_end && !frame_last;

  assign word_ready = bclk_en && ((start_req && !cfg_bad) || (!start_req && next_load));

  wire [2:0]    nxt_code = start_req ? len1_code :
                           ((elem_left == '0 || phase) ? len2_code : len1_code);
  wire [BW:0]   nlen  = code_bits(nxt_code);
  wire [BW:0]   pad   = (BW+1)'(WW) - nlen;
  wire [WW-1:0] ldata = word_valid ? word_in : last_word;
  wire          nlsb  = start_req ? (fmt_mode == 2'b01) : lsb_q;

  assign frame_active = active;
  assign sdo = active && (lsb_q ? shreg[0] : shreg[WW-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      last_word <= '0;
      bitcnt    <= '0;
      elem_left <= '0;
      phase     <= 1'b0;
      lsb_q     <= 1'b0;
      active    <= 1'b0;
      cfg_err   <= 1'b0;
      underrun  <= 1'b0;
    end else if (bclk_en) begin
      if (word_ready) begin
        last_word <= ldata;
        underrun  <= !word_valid;
        bitcnt    <= BW'(nlen - 1'b1);
        shreg     <= nlsb ? ldata : (ldata << pad);
      end
      if (start_req) begin
        cfg_err   <= cfg_bad;
        active    <= !cfg_bad;
        phase     <= 1'b0;
        elem_left <= cnt1;
        lsb_q     <= (fmt_mode == 2'b01);
        if (cfg_bad) shreg <= '0;
      end else if (active) begin
        if (bitcnt != '0) begin
          bitcnt <= bitcnt - 1'b1;
          shreg  <= lsb_q ? (shreg >> 1) : (shreg << 1);
        end else if (frame_last) begin
          active <= 1'b0;
          shreg  <= '0;
        end else if (elem_left == '0) begin
          phase     <= 1'b1;
          elem_left <= cnt2;
        end else begin
          elem_left <= elem_left - 1'b1;
        end
      end
    end
  end
endmodule

module ser2ph_tx_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bclk_en,
  input logic             fsync,
  input logic [2:0]       len1_code,
  input logic [2:0]       len2_code,
  input logic [CNT_W-1:0] cnt1,
  input logic [CNT_W-1:0] cnt2,
  input logic             one_phase,
  input logic [1:0]       fmt_mode,
  input logic             fs_ignore,
  input logic [31:0]      word_in,
  input logic             word_valid,
  input logic             word_ready,
  input logic             sdo,
  input logic             frame_active,
  input logic             cfg_err,
  input logic             underrun
);
  // R2
  active_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_active |-> !cfg_err);

  // R2
  mode_len_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_en && fsync && !frame_active && fmt_mode != 2'b00 && len1_code != 3'd0)
    |=> (cfg_err && !frame_active));

  // R5
  start_by_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) |-> ($past(fsync) && $past(bclk_en)));

  // R9
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> bclk_en);

  // R9
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && !word_valid) |=> underrun);

  // R9
  underrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && word_valid) |=> !underrun);

  // R10
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_en |=> ($stable(sdo) && $stable(frame_active)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |-> !sdo);
endmodule

bind ser2ph_tx ser2ph_tx_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/ser2ph_tx_tb.sv
module ser2ph_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_en = 1'b0, fsync = 1'b0;
  logic [2:0]  len1_code = '0, len2_code = '0, cnt1 = '0, cnt2 = '0;
  logic        one_phase = 1'b0, fs_ignore = 1'b0, word_valid = 1'b1;
  logic [1:0]  fmt_mode = '0;
  logic [31:0] word_in;
  logic        word_ready, sdo, frame_active, cfg_err, underrun;
  int          k = 0;
  int          checks = 0, errors = 0;
  bit          gap = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input int n);
    return 32'h5A3C_96E1 ^ (32'(n) * 32'h9E37_79B9);
  endfunction

  function automatic int blen(input logic [2:0] c);
    return (c == 3'd5) ? 32 : 8 + 4 * int'(c);
  endfunction

  assign word_in = pat(k);
  always @(posedge clk) if (word_ready && word_valid) k <= k + 1;

  ser2ph_tx u_dut (.*);

  // {one_phase, fmt_mode, len1, len2, cnt1, cnt2}
  localparam logic [14:0] VEC [7] = '{
    {1'b0, 2'd0, 3'd0, 3'd2, 3'd1, 3'd0},
    {1'b1, 2'd0, 3'd5, 3'd0, 3'd0, 3'd0},
    {1'b0, 2'd1, 3'd0, 3'd0, 3'd2, 3'd1},
    {1'b0, 2'd0, 3'd1, 3'd3, 3'd0, 3'd1},
    {1'b1, 2'd2, 3'd0, 3'd0, 3'd3, 3'd0},
    {1'b0, 2'd0, 3'd4, 3'd0, 3'd0, 3'd7},
    {1'b1, 2'd3, 3'd0, 3'd7, 3'd0, 3'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [14:0] v);
    {one_phase, fmt_mode, len1_code, len2_code, cnt1, cnt2} = v;
  endtask

  task automatic tick();
    if (gap) begin
      bclk_en = 1'b0;
      repeat (2) @(negedge clk);
    end
    bclk_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bclk_en = 1'b0;
  endtask

  task automatic start();
    fsync = 1'b1;
    tick();
    fsync = 1'b0;
  endtask

  // Called right after the tick that loaded element 1; checks a whole frame.
  task automatic stream(input logic [14:0] v, input int inj, input bit chain, input string tag);
    int kk, idx, total, bad, L, cnt, np, fa, fe, fi;
    logic [31:0] w;
    logic expb;
    bit lsb;
    kk = k - 1; idx = 0; bad = 0; fi = -1; fa = 0; fe = 0;
    lsb = (v[13:12] == 2'd1);
    np = v[14] ? 1 : 2;
    total = (int'(v[5:3]) + 1) * blen(v[11:9]);
    if (np == 2) total += (int'(v[2:0]) + 1) * blen(v[8:6]);
    for (int p = 0; p < np; p++) begin
      cnt = (p == 0) ? int'(v[5:3]) : int'(v[2:0]);
      L = blen((p == 0) ? v[11:9] : v[8:6]);
      for (int e = 0; e <= cnt; e++) begin
        w = pat(kk);
        kk++;
        for (int b = 0; b < L; b++) begin
          expb = lsb ? w[b] : w[L-1-b];
          if (sdo !== expb || frame_active !== 1'b1) begin
            if (fi < 0) begin fi = idx; fa = int'(sdo); fe = int'(expb); end
            bad++;
          end
          if (idx == total - 1) begin
            if (chain) fsync = 1'b1;
          end else if (idx == inj) fsync = 1'b1;
          tick();
          fsync = 1'b0;
          idx++;
        end
      end
    end
    if (bad != 0) $display("  first bit mismatch at index %0d", fi);
    chk(bad == 0, {tag, " stream bits"}, fa, fe);
    if (!chain) chk(frame_active == 1'b0, {tag, " R5 frame end"}, int'(frame_active), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(sdo == 0 && frame_active == 0, "R11 reset outputs", int'({sdo, frame_active}), 0);
    chk(cfg_err == 0 && underrun == 0 && word_ready == 0, "R11 reset flags",
        int'({cfg_err, underrun, word_ready}), 0);

    // R1 R3 R4 R5 R10: table of frames, odd rows with gaps between ticks
    for (int i = 0; i < 7; i++) begin
      gap = (i % 2 == 1);
      set_cfg(VEC[i]);
      start();
      stream(VEC[i], -1, 1'b0, $sformatf("R1/R3/R4 vec%0d", i));
    end
    gap = 1'b0;

    // R2: reserved length code
    set_cfg({1'b1, 2'd0, 3'd6, 3'd0, 3'd0, 3'd0});
    k0 = k;
    start();
    chk(cfg_err == 1 && frame_active == 0, "R2 reserved len1", int'({cfg_err, frame_active}), 2);
    chk(k == k0, "R2 no word taken", k, k0);
    // R2: bit-order mode with 16-bit length
    set_cfg({1'b1, 2'd1, 3'd2, 3'd0, 3'd0, 3'd0});
    start();
    chk(cfg_err == 1 && frame_active == 0, "R2 mode with len16", int'({cfg_err, frame_active}), 2);
    // R2: reserved phase-2 code when two phases in use
    set_cfg({1'b0, 2'd0, 3'd0, 3'd7, 3'd0, 3'd0});
    start();
    chk(cfg_err == 1 && frame_active == 0, "R2 reserved len2", int'({cfg_err, frame_active}), 2);
    set_cfg(VEC[0]);
    start();
    chk(cfg_err == 0, "R2 cleared by good start", int'(cfg_err), 0);
    stream(VEC[0], -1, 1'b0, "R2 recovery");

    // R6: restart mid-frame
    fs_ignore = 1'b0;
    set_cfg({1'b1, 2'd0, 3'd2, 3'd0, 3'd1, 3'd0});
    start();
    repeat (5) tick();
    k0 = k;
    start();
    chk(k == k0 + 1, "R6 restart takes word", k, k0 + 1);
    stream({1'b1, 2'd0, 3'd2, 3'd0, 3'd1, 3'd0}, -1, 1'b0, "R6 restart");

    // R7: mid-frame sync ignored
    fs_ignore = 1'b1;
    start();
    stream({1'b1, 2'd0, 3'd2, 3'd0, 3'd1, 3'd0}, 5, 1'b0, "R7 ignore");

    // R8: sync on the final tick chains frames
    set_cfg({1'b1, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0});
    start();
    stream({1'b1, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0}, -1, 1'b1, "R8 first");
    chk(frame_active == 1, "R8 chained start", int'(frame_active), 1);
    stream({1'b1, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0}, -1, 1'b0, "R8 second");
    fs_ignore = 1'b0;

    // R9: underrun repeats previous word
    begin
      logic [31:0] w;
      int bad;
      set_cfg({1'b1, 2'd0, 3'd0, 3'd0, 3'd1, 3'd0});
      start();
      w = pat(k - 1);
      word_valid = 1'b0;
      k0 = k;
      bad = 0;
      for (int i = 0; i < 16; i++) begin
        if (sdo !== w[7 - (i % 8)]) bad++;
        if (i == 8) chk(underrun == 1, "R9 underrun set", int'(underrun), 1);
        tick();
      end
      chk(bad == 0, "R9 repeated word bits", bad, 0);
      chk(k == k0, "R9 no word consumed", k, k0);
      word_valid = 1'b1;
      set_cfg(VEC[1]);
      start();
      chk(underrun == 0, "R9 underrun cleared", int'(underrun), 1'b0);
      stream(VEC[1], -1, 1'b0, "R9 after underrun");
    end

    // R10: idle with syncs off, no ticks: output stays quiet
    repeat (4) @(negedge clk);
    chk(sdo == 0 && frame_active == 0, "R10 idle quiet", int'({sdo, frame_active}), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule